// File: doc/BRIEF.md
# Infrared Receive Symbol Buffer

The block sits between an infrared sampler and the processor. The sampler hands over one run-length symbol byte at a time with a strobe, plus a separate strobe when a packet has ended. Symbols are queued in a byte FIFO whose depth is a parameter (16 or 64). Software drains the FIFO through a small register window and learns when to do so from sticky flags and one interrupt line.

The same window holds the settings that steer the sampler: global and receive enables, a two-bit mode, input polarity inversion, a noise threshold and an idle threshold. These are driven out as plain configuration ports. The interrupt-enable register carries a fill-level trigger, and the status register reports the live fill count next to the flags.

Register reads are registered: a read strobe in one cycle presents the word on the read-data port after that clock edge, and the port holds the value until the next read.

Top module: `ir_symbol_rx`

## Requirements
- R1: After reset every register reads zero, the FIFO is empty, the read-data port is zero, the interrupt is low and every configuration output is zero.
- R2: Accepted symbols leave in arrival order. Each read of offset 0x20 returns the oldest byte in bits 7:0, removes it, and lowers the fill count by one. The fill count is reported in the status word (offset 0x30) from bit 8 upward.
- R3: A symbol strobe while the FIFO holds DEPTH bytes drops the symbol and sets status bit 0. A strobe in the same cycle as a data read of a full FIFO is accepted, and bit 0 is not set.
- R4: A packet-end strobe sets status bit 1.
- R5: Status bit 4 becomes set at each clock edge where the fill count held before that edge is greater than the trigger level in bits 8 upward of the enable register (offset 0x2C, width log2(DEPTH)).
- R6: Writing the status register clears each flag whose bit is written as one and leaves the others unchanged, so 0xFF clears all. If a flag is set by its event in the same cycle it is cleared, it stays set.
- R7: The interrupt is high exactly when some status bit 0, 1 or 4 is set and the same bit is set in the enable register.
- R8: A data read of an empty FIFO returns zero and leaves the fill count unchanged.
- R9: The configuration registers read back and drive their outputs. Control (0x00) holds global enable in bit 0, receive enable in bit 1 and mode in bits 5:4. Receive config (0x10) holds polarity invert in bit 2. Sample config (0x34) holds the noise threshold in bits 7:2 and the idle threshold in bits 15:8. All other bits read zero.
- R10: The fill-count field is log2(DEPTH)+1 bits wide, so a full FIFO reports a count equal to DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sym_valid | input | 1 | Symbol strobe from the sampler |
| sym_data | input | 8 | Run-length symbol byte |
| pkt_end | input | 1 | Packet-end strobe from the sampler |
| irq | output | 1 | Interrupt request |
| cfg_glb_en | output | 1 | Global enable |
| cfg_rx_en | output | 1 | Receive enable |
| cfg_mode | output | 2 | Sampler mode |
| cfg_invert | output | 1 | Input polarity inversion |
| cfg_noise_thr | output | 6 | Noise threshold |
| cfg_idle_thr | output | 8 | Idle threshold |

## Verification
Two pairs of functions can meet in one cycle. A symbol can arrive in the same cycle as a data read of a full FIFO. A flag can be set by its event in the same cycle that software clears it. The bench drives the symbol strobe with the data read on a full FIFO, and drives the packet-end strobe with a status write that clears bit 1. A queue-based reference model, updated on every edge, decides the outcome: the push is accepted without an overflow flag, and the flag survives its clear. The following data read and status read show both results at the ports.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_RXCFG = 8'h10;
    localparam logic [7:0] OFF_DATA  = 8'h20;
    localparam logic [7:0] OFF_IEN   = 8'h2C;
    localparam logic [7:0] OFF_STAT  = 8'h30;
    localparam logic [7:0] OFF_SAMP  = 8'h34;

    localparam int BIT_OVF   = 0;
    localparam int BIT_PEND  = 1;
    localparam int BIT_AVAIL = 4;
    localparam int FIELD_LSB = 8;
    localparam int BIT_INV   = 2;

    typedef struct packed {
        logic avail;
        logic pend;
        logic ovf;
    } flags_t;

    typedef struct packed {
        logic [1:0] mode;
        logic       rx_en;
        logic       glb_en;
    } ctrl_t;

    function automatic logic [7:0] flags_to_byte(flags_t f);
        logic [7:0] b;
        b            = '0;
        b[BIT_OVF]   = f.ovf;
        b[BIT_PEND]  = f.pend;
        b[BIT_AVAIL] = f.avail;
        return b;
    endfunction

    function automatic flags_t byte_to_flags(logic [7:0] b);
        flags_t f;
        f.ovf   = b[BIT_OVF];
        f.pend  = b[BIT_PEND];
        f.avail = b[BIT_AVAIL];
        return f;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
        logic [7:0] b;
        b      = '0;
        b[0]   = c.glb_en;
        b[1]   = c.rx_en;
        b[5:4] = c.mode;
        return b;
    endfunction

    function automatic ctrl_t byte_to_ctrl(logic [7:0] b);
        ctrl_t c;
        c.glb_en = b[0];
        c.rx_en  = b[1];
        c.mode   = b[5:4];
        return c;
    endfunction

endpackage

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop_req,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             dropped
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, pop_go, push_go;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_go  = pop_req && !empty;
    assign push_go = push && (!full || pop_go);
    assign dropped = push && !push_go;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_go) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_go) wr_ptr <= wr_ptr + 1'b1;
            if (pop_go)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(push_go) - CNT_W'(pop_go);
        end
    end

    // R3, R10: the count never passes the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R2: the count moves by at most one per cycle
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1) ||
        (count == $past(count) - 1'b1));

    // R8: a read of an empty FIFO with no arrival keeps the count
    assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty && !push) |=> (count == '0));

endmodule

// File: rtl/ir_rx_status.sv
module ir_rx_status
    import ir_rx_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_ovf,
    input  logic             hit_pend,
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] level,
    input  logic             clr_we,
    input  flags_t           clr_mask,
    input  flags_t           enable,
    output flags_t           flags,
    output logic             irq
);
    flags_t hits, clears;

    always_comb begin
        hits.ovf   = hit_ovf;
        hits.pend  = hit_pend;
        hits.avail = count > CNT_W'(level);
        clears     = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clears) | hits;
        end
    end

    assign irq = |(flags & enable);

    // R4: a packet end is always recorded
    assert_pkt_end_R4: assert property (@(posedge clk) disable iff (rst)
        hit_pend |=> flags.pend);

    // R6: a set in the clearing cycle wins
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_mask.ovf && hit_ovf) |=> flags.ovf);

    // R6: a clear with no new event removes the flag
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_mask.pend && !hit_pend) |=> !flags.pend);

    // R5: fill above the trigger level sets the flag
    assert_avail_R5: assert property (@(posedge clk) disable iff (rst)
        (count > CNT_W'(level)) |=> flags.avail);

    // R7: no enabled bit, no interrupt
    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq);

endmodule

// File: rtl/ir_symbol_rx.sv
module ir_symbol_rx
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        sym_valid,
    input  logic [7:0]  sym_data,
    input  logic        pkt_end,
    output logic        irq,
    output logic        cfg_glb_en,
    output logic        cfg_rx_en,
    output logic [1:0]  cfg_mode,
    output logic        cfg_invert,
    output logic [5:0]  cfg_noise_thr,
    output logic [7:0]  cfg_idle_thr
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;
    localparam int LVL_W = AW;

    ctrl_t             ctrl_q;
    logic              inv_q;
    logic [5:0]        noise_q;
    logic [7:0]        idle_q;
    flags_t            en_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [31:0]       rdata_q;
    logic [31:0]       rd_word;

    logic [7:0]        head;
    logic [CNT_W-1:0]  count;
    logic              empty, dropped, pop_req, clr_we;
    flags_t            flags;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign pop_req = bus_rd && (bus_addr == OFF_DATA);
    assign clr_we  = bus_wr && (bus_addr == OFF_STAT);

    ir_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (sym_valid),
        .push_data (sym_data),
        .pop_req   (pop_req),
        .head      (head),
        .count     (count),
        .empty     (empty),
        .dropped   (dropped)
    );

    ir_rx_status #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .hit_ovf  (dropped),
        .hit_pend (pkt_end),
        .count    (count),
        .level    (lvl_q),
        .clr_we   (clr_we),
        .clr_mask (byte_to_flags(bus_wdata[7:0])),
        .enable   (en_q),
        .flags    (flags),
        .irq      (irq)
    );

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            OFF_CTRL:  rd_word[7:0] = ctrl_to_byte(ctrl_q);
            OFF_RXCFG: rd_word[BIT_INV] = inv_q;
            OFF_DATA:  rd_word[7:0] = empty ? 8'h00 : head;
            OFF_IEN: begin
                rd_word[7:0]                  = flags_to_byte(en_q);
                rd_word[FIELD_LSB +: LVL_W]   = lvl_q;
            end
            OFF_STAT: begin
                rd_word[7:0]                  = flags_to_byte(flags);
                rd_word[FIELD_LSB +: CNT_W]   = count;
            end
            OFF_SAMP: begin
                rd_word[7:2]  = noise_q;
                rd_word[15:8] = idle_q;
            end
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            inv_q   <= 1'b0;
            noise_q <= '0;
            idle_q  <= '0;
            en_q    <= '0;
            lvl_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (bus_rd) rdata_q <= rd_word;
            if (bus_wr) begin
                case (bus_addr)
                    OFF_CTRL:  ctrl_q <= byte_to_ctrl(bus_wdata[7:0]);
                    OFF_RXCFG: inv_q  <= bus_wdata[BIT_INV];
                    OFF_IEN: begin
                        en_q  <= byte_to_flags(bus_wdata[7:0]);
                        lvl_q <= bus_wdata[FIELD_LSB +: LVL_W];
                    end
                    OFF_SAMP: begin
                        noise_q <= bus_wdata[7:2];
                        idle_q  <= bus_wdata[15:8];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign bus_rdata     = rdata_q;
    assign cfg_glb_en    = ctrl_q.glb_en;
    assign cfg_rx_en     = ctrl_q.rx_en;
    assign cfg_mode      = ctrl_q.mode;
    assign cfg_invert    = inv_q;
    assign cfg_noise_thr = noise_q;
    assign cfg_idle_thr  = idle_q;

    // R3: a dropped symbol raises the overflow flag
    assert_drop_flag_R3: assert property (@(posedge clk) disable iff (rst)
        dropped |=> flags.ovf);

    // R8: an empty data read yields zero on the port
    assert_empty_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty) |=> (bus_rdata == '0));

    // R1: reset leaves the port quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && !irq));

endmodule

// File: tb/test_ir_symbol_rx.sv
module test_ir_symbol_rx;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sym_valid = 1'b0;
    logic [7:0]  sym_data = '0;
    logic        pkt_end = 1'b0;
    logic        irq, cfg_glb_en, cfg_rx_en, cfg_invert;
    logic [1:0]  cfg_mode;
    logic [5:0]  cfg_noise_thr;
    logic [7:0]  cfg_idle_thr;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ir_symbol_rx #(.DEPTH(DEPTH)) i_ir_symbol_rx (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sym_valid(sym_valid), .sym_data(sym_data), .pkt_end(pkt_end),
        .irq(irq), .cfg_glb_en(cfg_glb_en), .cfg_rx_en(cfg_rx_en),
        .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
        .cfg_noise_thr(cfg_noise_thr), .cfg_idle_thr(cfg_idle_thr)
    );

    // reference model
    byte unsigned q[$];
    bit [31:0] m_rdata;
    bit [7:0]  m_flags, m_en, m_ctrl, m_set, m_clr;
    bit [3:0]  m_lvl;
    bit        m_inv, m_pop;
    bit [15:0] m_samp;
    int        m_sz;

    function automatic bit m_irq();
        return |(m_flags & m_en & 8'h13);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_rdata = 0; m_flags = 0; m_en = 0; m_ctrl = 0;
            m_lvl = 0; m_inv = 0; m_samp = 0;
        end else begin
            m_sz  = q.size();
            m_pop = bus_rd && bus_addr == 8'h20 && m_sz > 0;
            if (bus_rd) begin
                case (bus_addr)
                    8'h00: m_rdata = {24'h0, m_ctrl};
                    8'h10: m_rdata = {29'h0, m_inv, 2'b00};
                    8'h20: m_rdata = (m_sz > 0) ? {24'h0, q[0]} : 32'h0;
                    8'h2C: m_rdata = {20'h0, m_lvl, m_en};
                    8'h30: m_rdata = {19'h0, 5'(m_sz), m_flags};
                    8'h34: m_rdata = {16'h0, m_samp};
                    default: m_rdata = 0;
                endcase
            end
            m_set = 0;
            if (sym_valid && m_sz == DEPTH && !m_pop) m_set[0] = 1;
            if (pkt_end) m_set[1] = 1;
            if (m_sz > int'(m_lvl)) m_set[4] = 1;
            m_clr = (bus_wr && bus_addr == 8'h30) ? bus_wdata[7:0] & 8'h13 : 8'h0;
            m_flags = (m_flags & ~m_clr) | m_set;
            if (m_pop) void'(q.pop_front());
            if (sym_valid && (m_sz < DEPTH || m_pop)) q.push_back(sym_data);
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_ctrl = bus_wdata[7:0] & 8'h33;
                    8'h10: m_inv  = bus_wdata[2];
                    8'h2C: begin m_en = bus_wdata[7:0] & 8'h13; m_lvl = bus_wdata[11:8]; end
                    8'h34: m_samp = bus_wdata[15:0] & 16'hFFFC;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            check({cur_req, " rdata"}, bus_rdata, m_rdata);
            check({cur_req, " irq R7"}, {31'h0, irq}, {31'h0, m_irq()});
            check("R9 cfg", {16'h0, cfg_glb_en, cfg_rx_en, cfg_mode, cfg_invert, cfg_noise_thr, cfg_idle_thr},
                  {16'h0, m_ctrl[0], m_ctrl[1], m_ctrl[5:4], m_inv, m_samp[7:2], m_samp[15:8]});
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        v = bus_rdata;
    endtask

    task automatic push(logic [7:0] b);
        sym_valid = 1; sym_data = b;
        @(negedge clk);
        sym_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        cur_req = "R1";
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h30, v); check("R1 status", v, 32'h0);
        rd(8'h2C, v); check("R1 enable", v, 32'h0);
        rd(8'h34, v); check("R1 sample", v, 32'h0);

        // R9 configuration
        cur_req = "R9";
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R9 ctrl", v, 32'h33);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R9 rxcfg", v, 32'h4);
        wr(8'h34, 32'h0000_A5B7);
        rd(8'h34, v); check("R9 sample", v, 32'hA5B4);
        check("R9 noise", {26'h0, cfg_noise_thr}, 32'h2D);
        check("R9 idle", {24'h0, cfg_idle_thr}, 32'hA5);
        wr(8'h00, 32'h0000_0021);
        check("R9 mode", {30'h0, cfg_mode}, 32'h2);

        // R2 ordering and count
        cur_req = "R2";
        wr(8'h2C, 32'h0000_0713);
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
        rd(8'h30, v); check("R2 count", v >> 8, 32'd5);
        rd(8'h20, v); check("R2 first", v, 32'hA0);
        rd(8'h20, v); check("R2 second", v, 32'hA1);
        rd(8'h30, v); check("R2 count after", v >> 8, 32'd3);

        // R3 and R10: overflow
        cur_req = "R3";
        for (int i = 0; i < 15; i++) push(8'hB0 + 8'(i));
        rd(8'h30, v);
        check("R10 full count", v >> 8, DEPTH);
        check("R3 overflow bit", v & 32'h1, 32'h1);
        check("R5 avail bit", v & 32'h10, 32'h10);
        wr(8'h30, 32'hFF);
        // pop and push together on a full FIFO
        bus_rd = 1; bus_addr = 8'h20; sym_valid = 1; sym_data = 8'hC0;
        @(negedge clk);
        bus_rd = 0; sym_valid = 0;
        check("R3 concurrent read", bus_rdata, 32'hA2);
        rd(8'h30, v);
        check("R3 no overflow on concurrent", v & 32'h1, 32'h0);
        check("R10 still full", v >> 8, DEPTH);
        rd(8'h20, v); check("R2 next oldest", v, 32'hA3);

        // R4 and R6: packet end against a clear
        cur_req = "R6";
        wr(8'h30, 32'hFF);
        pkt_end = 1; bus_wr = 1; bus_addr = 8'h30; bus_wdata = 32'h2;
        @(negedge clk);
        pkt_end = 0; bus_wr = 0;
        rd(8'h30, v); check("R6 set wins", v & 32'h2, 32'h2);
        check("R4 pend", v & 32'h2, 32'h2);
        wr(8'h30, 32'h2);
        rd(8'h30, v); check("R6 cleared", v & 32'h2, 32'h0);

        // R7 interrupt masking
        cur_req = "R7";
        wr(8'h2C, 32'h0);
        pkt_end = 1; @(negedge clk); pkt_end = 0;
        check("R7 masked", {31'h0, irq}, 32'h0);
        wr(8'h2C, 32'h0000_0F02);
        check("R7 enabled", {31'h0, irq}, 32'h1);
        wr(8'h30, 32'h02);
        @(negedge clk);
        check("R7 after clear", {31'h0, irq}, 32'h0);

        // R8 drain and empty read
        cur_req = "R8";
        for (int i = 0; i < DEPTH; i++) rd(8'h20, v);
        rd(8'h20, v); check("R8 empty data", v, 32'h0);
        rd(8'h30, v); check("R8 count zero", v >> 8, 32'h0);

        // R5 trigger level
        cur_req = "R5";
        wr(8'h2C, 32'h0000_0210);
        push(8'h11); push(8'h22);
        wr(8'h30, 32'hFF);
        repeat (2) @(negedge clk);
        rd(8'h30, v); check("R5 at level", v & 32'h10, 32'h0);
        push(8'h33);
        @(negedge clk);
        rd(8'h30, v); check("R5 above level", v & 32'h10, 32'h10);
        check("R5 irq", {31'h0, irq}, 32'h1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule